// File: doc/BRIEF.md
# Oversampled UART Receive Deserializer

This block turns an asynchronous serial line into parallel characters. It runs on the system clock and advances its bit timing on a clock-enable pulse at sixteen times the baud rate. When the idle line first goes low, the block starts a tick counter. Eight ticks later it samples the line again, at the middle of the start bit. A start bit that has already gone high is discarded, so a short glitch never becomes a character. Data bits, an optional parity bit and one or two stop bits are then each sampled at their centre, sixteen ticks apart.

When the last stop bit is sampled, the block presents the character right-justified in an 8-bit word. It also presents a parity-error flag, a framing-error flag and a break flag, and it pulses a valid strobe for one clock. Word length, parity and stop-bit count come from static configuration inputs. The block captures these at each start edge. After a framing error or a break, the receiver stays disarmed until the line has been seen high again. A line held low therefore cannot produce a stream of false characters.

Top module: `uart_rx_deser`

## Requirements
- R1: While idle and armed, a tick on which the synchronised line is low begins a start bit. The line is sampled again on the eighth following tick.
- R2: If the start-bit midpoint sample is high, the receiver returns to idle and produces no valid strobe for that attempt.
- R3: Data bits are sampled sixteen ticks apart, beginning sixteen ticks after the start midpoint. The first bit received lands in bit 0 of `rx_data_o`.
- R4: `wlen_sel_i` selects the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Bits of `rx_data_o` above the selected length are zero.
- R5: When `par_en_i` is 1, one parity bit follows the data. `par_even_i` = 1 selects even parity (data plus parity bit hold an even count of ones) and 0 selects odd parity. `par_err_o` is set on a mismatch and is always 0 when parity is disabled.
- R6: `two_stop_i` = 1 selects two stop bits and 0 selects one. `frm_err_o` is set when any stop-bit sample is low.
- R7: `brk_o` is set when every data bit, the parity bit (if enabled) and every stop bit sample low. A break always comes with `frm_err_o` = 1 and `rx_data_o` = 0.
- R8: After a character with a framing error or a break, no new start is detected until the line has been sampled high.
- R9: `valid_o` is high for exactly one clock per character, right after the last stop-bit sample. Data and flags change only together with `valid_o` and hold their values between strobes.
- R10: After synchronous reset, `valid_o`, `rx_data_o` and all flags are zero, and the receiver waits for the line to be high before arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| tick16_i | input | 1 | Clock enable at 16x the baud rate |
| wlen_sel_i | input | 2 | Data-bit count select (5 to 8) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop_i | input | 1 | 1 = two stop bits, 0 = one |
| rx_data_o | output | 8 | Received character, right-justified |
| par_err_o | output | 1 | Parity mismatch on the presented character |
| frm_err_o | output | 1 | A stop-bit sample was low |
| brk_o | output | 1 | The whole frame sampled low |
| valid_o | output | 1 | One-clock strobe for a new character |

## Verification
The bound checker covers the cycle-level rules on every clock: the strobe lasts a single cycle, and outputs stay still between strobes. It also checks that a rejected start returns to idle without a strobe, that a start is entered from idle on a low tick, and that unused high bits read zero. The remaining checks are that a break implies a framing error with zero data, that an error leaves the receiver disarmed, and that the parity flag stays clear with parity off. Correct bit order, parity polarity, stop-bit counting and tolerance of short glitches need whole serial frames. The scoreboard bench shows these by comparing every strobed character with the frame it drove. The bench also holds the line low after a break, to show that no phantom characters follow.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the oversampled UART receive deserializer.
// Assumes: a single receive channel; states are encoded locally.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_HIGH = 3'd0,
        ST_IDLE      = 3'd1,
        ST_START     = 3'd2,
        ST_DATA      = 3'd3,
        ST_PARITY    = 3'd4,
        ST_STOP1     = 3'd5,
        ST_STOP2     = 3'd6
    } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous serial input into the clock domain through a
// chain of flops. Assumes the line idles high, so every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] chain_q;

    // Purpose: shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
        end
    end

    assign line_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_tick_counter.sv
// Module: rx_tick_counter
// Counts oversampling ticks inside one bit period. A clear takes priority
// and zeroes the count. Assumes the controller clears it at each sample point.
module rx_tick_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Purpose: advance the count on each tick, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (tick_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/rx_bit_store.sv
// Module: rx_bit_store
// Holds the character being assembled. Each sampled bit is written to the
// position given by the controller, so short words stay right-justified
// and the unused upper bits keep the zero written by the clear.
module rx_bit_store #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o
);

    // Purpose: clear at start confirmation, then store sampled bits by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (clr_i) begin
            data_o <= '0;
        end else if (wr_i) begin
            data_o[idx_i] <= bit_i;
        end
    end

endmodule

// File: rtl/uart_rx_deser.sv
// Module: uart_rx_deser (top)
// Oversampled UART receiver. It confirms the start bit at its midpoint and
// samples data, parity and stop bits at their centres. It presents one
// character with parity, framing and break flags and a one-clock strobe.
// Assumes tick16_i is a one-clock pulse at OSR times the baud rate and that
// the configuration inputs are stable from start edge to start edge.
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MIN_BITS  = 5,
    parameter int OSR       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tick16_i,
    input  logic [1:0]        wlen_sel_i,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic              two_stop_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              brk_o,
    output logic              valid_o
);

    localparam int CNT_W  = $clog2(OSR);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int MID_AT = OSR / 2 - 1;
    localparam int END_AT = OSR - 1;

    rx_state_t         state_q;
    logic              line_s;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] data_q;
    logic [1:0]        wlen_q;
    logic              par_en_q;
    logic              par_even_q;
    logic              two_q;
    logic              par_bit_q;
    logic              stop1_low_q;

    logic start_det;
    logic mid_hit;
    logic bit_hit;
    logic cnt_clr;
    logic data_wr;
    logic final_stop;
    logic stop_low_any;
    logic stop_low_all;
    logic par_bad;
    logic brk_now;

    rx_line_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rxd_i),
        .line_o (line_s)
    );

    rx_tick_counter #(.CNT_W(CNT_W)) u_ticks (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick16_i),
        .clr_i  (cnt_clr),
        .cnt_o  (cnt)
    );

    rx_bit_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (mid_hit),
        .wr_i   (data_wr),
        .idx_i  (bit_idx_q),
        .bit_i  (line_s),
        .data_o (data_q)
    );

    // Purpose: decode sample points and the result of the closing stop bit.
    always_comb begin
        start_det  = (state_q == ST_IDLE) && tick16_i && !line_s;
        mid_hit    = (state_q == ST_START) && tick16_i && (cnt == CNT_W'(MID_AT));
        bit_hit    = tick16_i && (cnt == CNT_W'(END_AT)) &&
                     (state_q inside {ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2});
        cnt_clr    = start_det || mid_hit || bit_hit;
        data_wr    = bit_hit && (state_q == ST_DATA);
        last_idx   = IDX_W'(MIN_BITS - 1) + IDX_W'(wlen_q);
        final_stop = bit_hit && (((state_q == ST_STOP1) && !two_q) || (state_q == ST_STOP2));
        stop_low_any = !line_s || (two_q && stop1_low_q);
        stop_low_all = !line_s && (!two_q || stop1_low_q);
        par_bad    = par_en_q && ((^data_q) ^ par_bit_q ^ !par_even_q);
        brk_now    = (data_q == '0) && (!par_en_q || !par_bit_q) && stop_low_all;
    end

    // Purpose: frame sequencer, configuration capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_WAIT_HIGH;
            bit_idx_q   <= '0;
            wlen_q      <= '0;
            par_en_q    <= 1'b0;
            par_even_q  <= 1'b0;
            two_q       <= 1'b0;
            par_bit_q   <= 1'b0;
            stop1_low_q <= 1'b0;
            rx_data_o   <= '0;
            par_err_o   <= 1'b0;
            frm_err_o   <= 1'b0;
            brk_o       <= 1'b0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                ST_WAIT_HIGH: begin
                    if (line_s) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (start_det) begin
                        state_q    <= ST_START;
                        wlen_q     <= wlen_sel_i;
                        par_en_q   <= par_en_i;
                        par_even_q <= par_even_i;
                        two_q      <= two_stop_i;
                    end
                end
                ST_START: begin
                    if (mid_hit) begin
                        state_q   <= line_s ? ST_IDLE : ST_DATA;
                        bit_idx_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (bit_hit) begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                        if (bit_idx_q == last_idx) begin
                            state_q <= par_en_q ? ST_PARITY : ST_STOP1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (bit_hit) begin
                        par_bit_q <= line_s;
                        state_q   <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (bit_hit) begin
                        stop1_low_q <= !line_s;
                        state_q     <= ST_STOP2;
                    end
                end
                ST_STOP2: begin
                    if (bit_hit) state_q <= ST_IDLE;
                end
                default: state_q <= ST_WAIT_HIGH;
            endcase

            if (final_stop) begin
                rx_data_o <= data_q;
                par_err_o <= par_bad;
                frm_err_o <= stop_low_any;
                brk_o     <= brk_now;
                valid_o   <= 1'b1;
                state_q   <= stop_low_any ? ST_WAIT_HIGH : ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/uart_rx_deser_chk.sv
// Module: uart_rx_deser_chk
// Property checker bound into uart_rx_deser. It observes ports and the
// sequencer state and changes nothing. Assumes the default 8-bit word.
module uart_rx_deser_chk
    import uart_rx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int CNT_W    = 4,
    parameter int MID_AT   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16_i,
    input logic              line_s,
    input rx_state_t         state_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [1:0]        wlen_q,
    input logic              par_en_q,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              par_err_o,
    input logic              frm_err_o,
    input logic              brk_o,
    input logic              valid_o
);

    logic upper_ok;

    // Purpose: confirm that no data bit above the selected length is set.
    always_comb begin
        upper_ok = 1'b1;
        for (int i = 0; i < DATA_W; i++) begin
            if (rx_data_o[i] && (i >= MIN_BITS + int'(wlen_q))) upper_ok = 1'b0;
        end
    end

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tick16_i && !line_s) |=> (state_q == ST_START)); // R1

    AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick16_i && cnt == CNT_W'(MID_AT) && line_s)
        |=> (state_q == ST_IDLE && !valid_o)); // R2

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> upper_ok); // R4

    AST_NO_PERR_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !par_en_q) |-> !par_err_o); // R5

    AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && brk_o) |-> (frm_err_o && rx_data_o == '0)); // R7

    AST_ERR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && frm_err_o) |-> (state_q == ST_WAIT_HIGH)); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9

    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(rx_data_o) && $stable({par_err_o, frm_err_o, brk_o}))); // R9

endmodule

bind uart_rx_deser uart_rx_deser_chk #(
    .DATA_W   (DATA_W),
    .MIN_BITS (MIN_BITS),
    .CNT_W    (CNT_W),
    .MID_AT   (MID_AT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16_i  (tick16_i),
    .line_s    (line_s),
    .state_q   (state_q),
    .cnt       (cnt),
    .wlen_q    (wlen_q),
    .par_en_q  (par_en_q),
    .rx_data_o (rx_data_o),
    .par_err_o (par_err_o),
    .frm_err_o (frm_err_o),
    .brk_o     (brk_o),
    .valid_o   (valid_o)
);

// File: tb/uart_rx_deser_bench.sv
// Bench: scoreboard for uart_rx_deser. A driver task serialises frames and
// queues the character it expects. A monitor pops and compares on every strobe.
module uart_rx_deser_bench;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wlen_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       two_stop = 1'b0;
    logic [7:0] rx_data;
    logic       par_err;
    logic       frm_err;
    logic       brk;
    logic       valid;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    logic [10:0] exp_q[$];
    string       tag_q[$];

    uart_rx_deser u_uart_rx_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd_i      (rxd),
        .tick16_i   (tick),
        .wlen_sel_i (wlen_sel),
        .par_en_i   (par_en),
        .par_even_i (par_even),
        .two_stop_i (two_stop),
        .rx_data_o  (rx_data),
        .par_err_o  (par_err),
        .frm_err_o  (frm_err),
        .brk_o      (brk),
        .valid_o    (valid)
    );

    always #10 clk = ~clk;

    // Oversampling tick: one clock high every TICK_DIV clocks.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic check(input string tag, input logic ok, input string got, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %s expected %s", tag, got, exp);
        end
    endtask

    // Monitor: compare each strobed character with the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    check("R9", 1'b0, $sformatf("unexpected char %h", rx_data), "no strobe");
                end else begin
                    logic [10:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {brk, frm_err, par_err, rx_data} == e,
                          $sformatf("d=%h pe=%b fe=%b bk=%b", rx_data, par_err, frm_err, brk),
                          $sformatf("d=%h pe=%b fe=%b bk=%b", e[7:0], e[8], e[9], e[10]));
                end
            end
        end
    end

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Driver: serialise one frame and queue the expected result.
    task automatic send_frame(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                              input logic peven, input logic two, input logic flip_par,
                              input logic s1, input logic s2, input int low_hold,
                              input string tag);
        int nb;
        logic [7:0] dm;
        logic pbit;
        logic fe;
        logic bk;
        @(negedge clk);
        wlen_sel = wl;
        par_en   = pen;
        par_even = peven;
        two_stop = two;
        nb   = 5 + int'(wl);
        dm   = d & 8'((1 << nb) - 1);
        pbit = (^dm) ^ !peven ^ flip_par;
        fe   = !s1 || (two && !s2);
        bk   = (dm == 8'h00) && (!pen || !pbit) && !s1 && (!two || !s2);
        exp_q.push_back({bk, fe, pen && flip_par, dm});
        tag_q.push_back(tag);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(dm[i]);
        if (pen) drive_bit(pbit);
        drive_bit(s1);
        if (two) drive_bit(s2);
        repeat (low_hold * BIT_CLKS) @(negedge clk);
        drive_bit(1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", valid == 1'b0, $sformatf("%b", valid), "0");
        check("R10", rx_data == 8'h00 && !par_err && !frm_err && !brk,
              $sformatf("%h%b%b%b", rx_data, par_err, frm_err, brk), "000000");
        repeat (BIT_CLKS) @(negedge clk);

        // R1 R3: 8N1 patterns, bit order LSB first
        send_frame(8'hA5, 2'd3, 0, 0, 0, 0, 1, 1, 0, "R3");
        send_frame(8'h01, 2'd3, 0, 0, 0, 0, 1, 1, 0, "R3");
        send_frame(8'h80, 2'd3, 0, 0, 0, 0, 1, 1, 0, "R1");
        // R4: short words with upper bits that must not appear
        send_frame(8'hFF, 2'd0, 0, 0, 0, 0, 1, 1, 0, "R4");
        send_frame(8'hEA, 2'd1, 0, 0, 0, 0, 1, 1, 0, "R4");
        send_frame(8'hD3, 2'd2, 0, 0, 0, 0, 1, 1, 0, "R4");
        // R5: parity even/odd, good and corrupted
        send_frame(8'h37, 2'd3, 1, 1, 0, 0, 1, 1, 0, "R5");
        send_frame(8'h37, 2'd3, 1, 0, 0, 0, 1, 1, 0, "R5");
        send_frame(8'h5C, 2'd3, 1, 1, 0, 1, 1, 1, 0, "R5");
        send_frame(8'h0E, 2'd2, 1, 0, 0, 1, 1, 1, 0, "R5");
        // R6: two stop bits, clean and with second stop low
        send_frame(8'h3C, 2'd3, 0, 0, 1, 0, 1, 1, 0, "R6");
        send_frame(8'h3C, 2'd3, 0, 0, 1, 0, 1, 0, 0, "R6");
        send_frame(8'h55, 2'd3, 0, 0, 0, 0, 0, 1, 0, "R6");

        // R2: glitch shorter than half a bit yields no character
        v0 = n_valid;
        @(negedge clk);
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        check("R2", n_valid == v0, $sformatf("%0d strobes", n_valid - v0), "0 strobes");
        send_frame(8'hC3, 2'd3, 0, 0, 0, 0, 1, 1, 0, "R2");

        // R7 R8: break, line held low for three more bit times
        v0 = n_valid;
        send_frame(8'h00, 2'd3, 0, 0, 0, 0, 0, 0, 3, "R7");
        check("R8", n_valid == v0 + 1, $sformatf("%0d strobes", n_valid - v0), "1 strobe");
        send_frame(8'h00, 2'd3, 1, 1, 1, 0, 0, 0, 2, "R7");
        send_frame(8'h96, 2'd3, 0, 0, 0, 0, 1, 1, 0, "R8");

        repeat (2 * BIT_CLKS) @(negedge clk);
        // R9: every queued frame produced exactly one strobe
        check("R9", exp_q.size() == 0, $sformatf("%0d pending", exp_q.size()), "0 pending");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule